// File: doc/BRIEF.md
# Framed 16-bit serial register loader

This block is the write-only receive side of a three-wire serial port. A host holds an active-low frame line low and clocks data on a serial clock; the block takes one bit on each falling serial clock edge, most significant bit first. Every sixteen falling edges inside a frame make one word, so a host may send one word per frame or stream several words back to back without lifting the frame line. While the frame line is high the serial clock is ignored, which lets the clock run freely or rest at either level between transfers.

Each finished word is parked in a holding register in the serial clock domain, and a toggle flag carries the event across a two-flop synchronizer into the master clock domain. There a one-cycle strobe moves the word to its destination, chosen by its two top bits. A word with both top bits at zero replaces the 16-bit control register, which is presented on the output through a stage clocked on the falling master clock edge. Any other word leaves as a single-cycle write on a small address/data port toward the frequency and phase register bank.

Top module: `serial_word_loader`

## Requirements
- R1: After master reset the control output is 0x0000 and the bank write strobe is low.
- R2: A frame of sixteen falling serial clock edges whose first two bits are 00 sets the control output to the sixteen bits received, first bit received in bit 15.
- R3: A word whose bits 15:14 are not 00 produces a bank write with address equal to bits 15:14 (01, 10 or 11) and data equal to bits 13:0.
- R4: Several words sent within one frame are each delivered, in the order they were sent.
- R5: Fewer than sixteen falling edges before the frame line rises produce no write and do not carry over into the next frame.
- R6: Serial clock edges while the frame line is high change neither the control output nor the bank port.
- R7: Words are received correctly whether the serial clock rests high or low between frames.
- R8: A control word produces no bank write, and a bank word leaves the control output unchanged.
- R9: Each bank word raises the bank write strobe for exactly one master clock cycle.
- R10: The control output changes only on a falling edge of the master clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Master clock |
| mrst_n | input | 1 | Asynchronous active-low reset for both domains |
| sclk | input | 1 | Serial clock, data taken on its falling edge |
| frame_n | input | 1 | Active-low frame and enable line |
| sdata | input | 1 | Serial data, most significant bit first |
| ctrl_q | output | 16 | Control register, updated on the falling master clock edge |
| bank_we | output | 1 | One-cycle write strobe toward the register bank |
| bank_addr | output | 2 | Destination select, bits 15:14 of the word |
| bank_wdata | output | 14 | Payload, bits 13:0 of the word |

## Verification
Every master clock cycle the assertions check that a synchronized word strobe turns into a bank write exactly when its top bits are non-zero, that bank writes last one cycle and never carry address 00, and that the control output moves only on a falling master edge two samples after a control load. Bit ordering, the framing of back-to-back words, the discard of partial words, the ignoring of clock edges outside a frame and both idle levels of the serial clock are visible only at the ports after whole serial sequences, so the bench's directed and random frames show them against its own word model.

// File: rtl/sword_pkg.sv
package sword_pkg;
  localparam int WORD_W = 16;
  localparam int SEL_W  = 2;
  localparam int PAY_W  = WORD_W - SEL_W;

  function automatic logic [SEL_W-1:0] word_sel(input logic [WORD_W-1:0] w);
    return w[WORD_W-1 -: SEL_W];
  endfunction

  function automatic logic [PAY_W-1:0] word_payload(input logic [WORD_W-1:0] w);
    return w[PAY_W-1:0];
  endfunction

  function automatic logic is_ctrl_word(input logic [WORD_W-1:0] w);
    return word_sel(w) == '0;
  endfunction
endpackage

// File: rtl/sclk_shifter.sv
module sclk_shifter #(
  parameter int WORD_W = sword_pkg::WORD_W
) (
  input  logic              sclk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic              sdata,
  output logic [WORD_W-1:0] word_hold,
  output logic              word_tog
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0]  bit_cnt;
  logic [WORD_W-2:0] shreg;
  logic              last_bit;

  assign last_bit = (bit_cnt == LAST);

  // frame release clears the position: partial words never carry over
  always_ff @(negedge sclk or negedge rst_n or posedge frame_n) begin
    if (!rst_n)        bit_cnt <= '0;
    else if (frame_n)  bit_cnt <= '0;
    else if (last_bit) bit_cnt <= '0;
    else               bit_cnt <= bit_cnt + 1'b1;
  end

  always_ff @(negedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      shreg     <= '0;
      word_hold <= '0;
      word_tog  <= 1'b0;
    end else if (!frame_n) begin
      shreg <= {shreg[WORD_W-3:0], sdata};
      if (last_bit) begin
        word_hold <= {shreg, sdata};
        word_tog  <= ~word_tog;
      end
    end
  end
endmodule

// File: rtl/toggle_pulse_sync.sv
module toggle_pulse_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tog_in,
  output logic pulse
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], tog_in};
  end

  assign pulse = chain[STAGES] ^ chain[STAGES-1];
endmodule

// File: rtl/word_router.sv
module word_router
  import sword_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic [WORD_W-1:0] word,
  output logic              ctrl_load,
  output logic [WORD_W-1:0] ctrl_word,
  output logic              bank_we,
  output logic [SEL_W-1:0]  bank_addr,
  output logic [PAY_W-1:0]  bank_wdata
);
  assign ctrl_load = strobe && is_ctrl_word(word);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_word  <= '0;
      bank_we    <= 1'b0;
      bank_addr  <= '0;
      bank_wdata <= '0;
    end else begin
      bank_we <= strobe && !is_ctrl_word(word);
      if (ctrl_load) ctrl_word <= word;
      if (strobe && !is_ctrl_word(word)) begin
        bank_addr  <= word_sel(word);
        bank_wdata <= word_payload(word);
      end
    end
  end
endmodule

// File: rtl/serial_word_loader.sv
module serial_word_loader
  import sword_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              mclk,
  input  logic              mrst_n,
  input  logic              sclk,
  input  logic              frame_n,
  input  logic              sdata,
  output logic [WORD_W-1:0] ctrl_q,
  output logic              bank_we,
  output logic [SEL_W-1:0]  bank_addr,
  output logic [PAY_W-1:0]  bank_wdata
);
  logic [WORD_W-1:0] word_hold;
  logic              word_tog;
  logic              word_strobe;
  logic [SEL_W-1:0]  word_top;
  logic              ctrl_load;
  logic [WORD_W-1:0] ctrl_word;

  sclk_shifter #(.WORD_W(WORD_W)) u_shift (
    .sclk     (sclk),
    .rst_n    (mrst_n),
    .frame_n  (frame_n),
    .sdata    (sdata),
    .word_hold(word_hold),
    .word_tog (word_tog)
  );

  toggle_pulse_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (mclk),
    .rst_n (mrst_n),
    .tog_in(word_tog),
    .pulse (word_strobe)
  );

  assign word_top = word_sel(word_hold);

  word_router u_route (
    .clk       (mclk),
    .rst_n     (mrst_n),
    .strobe    (word_strobe),
    .word      (word_hold),
    .ctrl_load (ctrl_load),
    .ctrl_word (ctrl_word),
    .bank_we   (bank_we),
    .bank_addr (bank_addr),
    .bank_wdata(bank_wdata)
  );

  // control bits are presented on the falling master edge
  always_ff @(negedge mclk or negedge mrst_n) begin
    if (!mrst_n) ctrl_q <= '0;
    else         ctrl_q <= ctrl_word;
  end
endmodule

// File: rtl/word_loader_chk.sv
module word_loader_chk
  import sword_pkg::*;
(
  input logic              mclk,
  input logic              mrst_n,
  input logic              word_strobe,
  input logic [SEL_W-1:0]  word_top,
  input logic              ctrl_load,
  input logic              bank_we,
  input logic [SEL_W-1:0]  bank_addr,
  input logic [WORD_W-1:0] ctrl_q
);
  p_dest_r3: assert property (@(posedge mclk) disable iff (!mrst_n)
    word_strobe |=> (bank_we == ($past(word_top) != '0)));

  p_bank_addr_r8: assert property (@(posedge mclk) disable iff (!mrst_n)
    bank_we |-> (bank_addr != '0));

  p_we_single_r9: assert property (@(posedge mclk) disable iff (!mrst_n)
    bank_we |=> !bank_we);

  p_ctrl_edge_r10: assert property (@(negedge mclk) disable iff (!mrst_n)
    (ctrl_q != $past(ctrl_q)) |-> $past(ctrl_load, 2));
endmodule

bind serial_word_loader word_loader_chk u_chk (
  .mclk       (mclk),
  .mrst_n     (mrst_n),
  .word_strobe(word_strobe),
  .word_top   (word_top),
  .ctrl_load  (ctrl_load),
  .bank_we    (bank_we),
  .bank_addr  (bank_addr),
  .ctrl_q     (ctrl_q)
);

// File: tb/sim_serial_word_loader.sv
`timescale 1ns/100ps
module sim_serial_word_loader;
  logic        mclk = 1'b0;
  logic        mrst_n = 1'b0;
  logic        sclk = 1'b1;
  logic        frame_n = 1'b1;
  logic        sdata = 1'b0;
  logic [15:0] ctrl_q;
  logic        bank_we;
  logic [1:0]  bank_addr;
  logic [13:0] bank_wdata;

  serial_word_loader u0 (
    .mclk(mclk), .mrst_n(mrst_n), .sclk(sclk), .frame_n(frame_n), .sdata(sdata),
    .ctrl_q(ctrl_q), .bank_we(bank_we), .bank_addr(bank_addr), .bank_wdata(bank_wdata)
  );

  always #2.5 mclk = ~mclk;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  logic [15:0] got [0:255];
  int          got_n = 0;
  logic [15:0] exp_w [0:255];
  int          exp_n = 0;
  int          seen_n = 0;
  logic [15:0] exp_ctrl = 16'h0000;
  logic [15:0] fw [0:7];
  int          we_long = 0;
  int          bad_edge = 0;
  logic        prev_we = 1'b0;

  function automatic bit bench_is_ctrl(input logic [15:0] w);
    return (w >> 14) == 0;
  endfunction

  always @(negedge mclk) begin
    if (mrst_n && bank_we) begin
      if (got_n < 256) got[got_n] = {bank_addr, bank_wdata};
      got_n++;
      if (prev_we) we_long++;
    end
    prev_we = bank_we;
  end

  always @(ctrl_q) begin
    if ($realtime > 0) begin
      if ((longint'($realtime * 10.0) % 50) != 0) bad_edge++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    vectors++;
    if (act !== expv) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic bit_out(input logic b);
    sclk = 1'b1; sdata = b; #20;
    sclk = 1'b0; #20;
  endtask

  task automatic send_frame(input int n, input int tail, input bit idle_hi);
    frame_n = 1'b0; #20;
    for (int i = 0; i < n; i++) begin
      for (int b = 15; b >= 0; b--) bit_out(fw[i][b]);
      if (bench_is_ctrl(fw[i])) exp_ctrl = fw[i];
      else begin exp_w[exp_n] = fw[i]; exp_n++; end
    end
    for (int t = 0; t < tail; t++) bit_out(1'($urandom % 2));
    #20 frame_n = 1'b1;
    #20 sclk = idle_hi;
    #20;
  endtask

  task automatic settle(input string req);
    repeat (12) @(posedge mclk);
    #1;
    check({req, " ctrl"}, {16'h0, ctrl_q}, {16'h0, exp_ctrl});
    check({req, " count"}, got_n, exp_n);
    for (int i = seen_n; i < exp_n && i < 256; i++)
      check({req, " word"}, {16'h0, got[i]}, {16'h0, exp_w[i]});
    seen_n = exp_n;
  endtask

  initial begin
    #500us;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    #22 mrst_n = 1'b1;
    #10;
    // R1 reset state
    check("R1 ctrl", {16'h0, ctrl_q}, 32'h0);
    check("R1 we", {31'h0, bank_we}, 32'h0);

    // R2 control word, idle high, R7
    fw[0] = 16'h1234; send_frame(1, 0, 1'b1); settle("R2");
    // R3 bank word, idle low, R8 ctrl unchanged, R7
    fw[0] = 16'h4ABC; send_frame(1, 0, 1'b0); settle("R3 R8");
    fw[0] = 16'hFFFF; send_frame(1, 0, 1'b0); settle("R3 addr11");
    // R4 stream of words in one frame
    fw[0] = 16'hC001; fw[1] = 16'h2155; fw[2] = 16'h8FFF;
    send_frame(3, 0, 1'b1); settle("R4");
    // R5 partial words discarded
    send_frame(0, 9, 1'b1); settle("R5 partial");
    fw[0] = 16'h5A5A; send_frame(1, 15, 1'b0); settle("R5 tail");
    fw[0] = 16'h0A5A; send_frame(1, 0, 1'b0); settle("R5 fresh");
    // R6 edges with the frame high
    for (int k = 0; k < 40; k++) begin
      sdata = 1'($urandom % 2); sclk = 1'b1; #20; sclk = 1'b0; #20;
    end
    settle("R6");
    fw[0] = 16'h3C3C; send_frame(1, 0, 1'b1); settle("R6 after");

    // random frames, R4 and R7
    for (int f = 0; f < 50; f++) begin
      int n;
      n = 1 + ($urandom % 3);
      for (int i = 0; i < n; i++) fw[i] = 16'($urandom);
      send_frame(n, ($urandom % 4 == 0) ? int'(1 + $urandom % 15) : 0, 1'($urandom % 2));
      settle("R4 R7 random");
    end

    check("R9 single cycle", we_long, 0);
    check("R10 falling edge", bad_edge, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule